// File: doc/BRIEF.md
# DMA Address Translation Unit

This block turns a 32-bit address issued by a device on the I/O bus into a 48-bit system address. It does this one request at a time, with one cycle of latency. The top two address bits choose one of three windows:

- **Low quarter:** treated as local. The address is passed through unchanged and flagged as not forwarded.
- **Second quarter:** page-mapped in 4 KB pages through a 128-entry on-chip table. Each 64-bit entry supplies the page frame, a target ID and four ordering/caching attributes.
- **Upper half:** offset by a programmable direct-map segment and then shifted onto a fixed system RAM base.

Software fills the page table through a register port. The port takes an index and 64-bit write data, and it returns the selected entry one cycle later. A second small port loads the direct-map segment (offset and target ID). The segment can be read back as one 32-bit word.

A mapped request that hits an invalid entry, or whose page index lies outside the table, is consumed without producing an output. Instead, an error strobe pulses for one cycle.

Top module: `dma_xlate`

## Requirements
- R1: After reset, `out_valid` and `err_invalid` are 0 and `in_ready` is 1. Every table entry reads as 0, and `dm_rdata` is 0.
- R2: An accepted address below 0x4000_0000 appears one cycle later with:
  - `out_addr` equal to the address zero-extended to 48 bits;
  - `out_local`=1;
  - `out_target`=0;
  - all four attribute outputs 0.
- R3: An accepted address in 0x4000_0000..0x7FFF_FFFF uses page index (addr-0x4000_0000)>>12. If that entry is valid, the result one cycle later is:
  - `out_addr` = {entry[47:12], addr[11:0]};
  - `out_target` = entry[11:8];
  - `out_coherent` = entry[1], `out_precise` = entry[2], `out_prefetch` = entry[3], `out_barrier` = entry[4];
  - `out_local` = 0.
- R4: A mapped request fails when its page index is 128 or more, or when entry bit 0 (valid) is clear. A failed request gives `err_invalid`=1 for exactly the next cycle and no `out_valid`.
- R5: An accepted address at or above 0x8000_0000 gives `out_addr` = (offset·2^31 + addr[30:0] + RAM_BASE) mod 2^48. The other outputs are:
  - `out_target` = the segment's target ID;
  - `out_local` = 0;
  - all attribute outputs 0.
- R6: A table write lands at the next clock. A translation accepted in the same cycle as a write to the same entry uses the old entry.
- R7: `tbl_rdata` shows the full 64-bit entry selected by `tbl_idx` in the previous cycle, as it stood before any write made in that cycle. This includes the 16-bit remote field in bits 63:48.
- R8: `dm_we` loads `dm_off_in` and `dm_wid_in` at the next clock. `dm_rdata` returns the offset in bits 16:0 and the target ID in bits 23:20. All other bits of `dm_rdata` are 0.
- R9: `in_ready` = !`out_valid` || `out_ready`. While `out_valid` is high and `out_ready` is low, all outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted when high with in_valid |
| in_addr | input | 32 | Bus-side DMA address |
| out_valid | output | 1 | Translated result valid |
| out_ready | input | 1 | Consumer takes result |
| out_addr | output | 48 | System address |
| out_target | output | 4 | Destination target ID |
| out_barrier | output | 1 | Barrier attribute |
| out_prefetch | output | 1 | Prefetch attribute |
| out_precise | output | 1 | Precise attribute |
| out_coherent | output | 1 | Coherent attribute |
| out_local | output | 1 | Local window, not forwarded |
| err_invalid | output | 1 | One-cycle strobe for a failed mapped request |
| tbl_we | input | 1 | Table write enable |
| tbl_idx | input | 7 | Table entry index for write and read |
| tbl_wdata | input | 64 | Table write data |
| tbl_rdata | output | 64 | Registered table read data |
| dm_we | input | 1 | Direct-map segment write enable |
| dm_off_in | input | 17 | Direct-map offset to load |
| dm_wid_in | input | 4 | Direct-map target ID to load |
| dm_rdata | output | 32 | Packed direct-map segment read-back |

## Verification
The assertions check, on every cycle, the properties that hold in general:
- an error strobe never coincides with a valid result;
- a stalled result holds;
- a local result never carries high address bits or a target;
- a good mapped or direct request always produces a result one cycle later, carrying the segment target it was issued under;
- every table write lands in its entry.

The exact arithmetic needs the bench's scenarios:
- the frame splice;
- the wrap of the direct-map sum;
- the old-value rule for a translation that races a write to the same entry;
- the out-of-range page just past the table.

The bench checks these against its own model on every clock.

// File: rtl/dxl_pkg.sv
package dxl_pkg;

    localparam int ENT_W      = 64;
    localparam int VALID_BIT  = 0;
    localparam int ATTR_LSB   = 1;
    localparam int ATTR_W     = 4;
    localparam int TGT_LSB    = 8;
    localparam int TGT_W      = 4;
    localparam int FRAME_LSB  = 12;
    localparam int FRAME_MSB  = 47;
    localparam int FRAME_W    = FRAME_MSB - FRAME_LSB + 1;
    localparam int PAGE_SHIFT = FRAME_LSB;
    localparam int SYS_AW     = FRAME_MSB + 1;

    typedef enum logic [1:0] {
        WIN_LOCAL  = 2'd0,
        WIN_MAPPED = 2'd1,
        WIN_DIRECT = 2'd2
    } win_e;

    // ordering matches entry bits 4..1
    typedef struct packed {
        logic barrier;
        logic prefetch;
        logic precise;
        logic coherent;
    } attr_t;

    typedef struct packed {
        logic                 valid;
        attr_t                attr;
        logic [TGT_W-1:0]     tgt;
        logic [FRAME_W-1:0]   frame;
    } lookup_t;

endpackage

// File: rtl/dxl_window_decode.sv
module dxl_window_decode
    import dxl_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 128
) (
    input  logic [ADDR_W-PAGE_SHIFT-1:0] page_bits,
    output win_e                         win,
    output logic [$clog2(DEPTH)-1:0]     page_idx,
    output logic                         idx_in_range
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int PN_W  = ADDR_W - 2 - PAGE_SHIFT;

    logic [1:0]      sel;
    logic [PN_W-1:0] page_num;

    always_comb begin
        sel      = page_bits[ADDR_W-PAGE_SHIFT-1 -: 2];
        page_num = page_bits[PN_W-1:0];
        unique case (sel)
            2'b00:   win = WIN_LOCAL;
            2'b01:   win = WIN_MAPPED;
            default: win = WIN_DIRECT;
        endcase
        page_idx     = page_num[IDX_W-1:0];
        idx_in_range = (page_num < PN_W'(DEPTH));
    end

endmodule

// File: rtl/dxl_xlate_table.sv
module dxl_xlate_table
    import dxl_pkg::*;
#(
    parameter int DEPTH = 128
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [$clog2(DEPTH)-1:0] host_idx,
    input  logic [ENT_W-1:0]         wr_data,
    output logic [ENT_W-1:0]         rd_data,
    input  logic [$clog2(DEPTH)-1:0] lk_idx,
    output lookup_t                  lk
);
    localparam int IDX_W = $clog2(DEPTH);

    logic [ENT_W-1:0] ent_d [DEPTH];
    logic [ENT_W-1:0] ent_q [DEPTH];
    logic [ENT_W-1:0] rd_d, rd_q;
    logic [ENT_W-1:0] sel_ent;

    always_comb begin
        ent_d = ent_q;
        if (wr_en) ent_d[host_idx] = wr_data;
        rd_d = ent_q[host_idx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
            rd_q <= '0;
        end else begin
            ent_q <= ent_d;
            rd_q  <= rd_d;
        end
    end

    always_comb begin
        sel_ent   = ent_q[lk_idx];
        lk.valid  = sel_ent[VALID_BIT];
        lk.attr   = sel_ent[ATTR_LSB +: ATTR_W];
        lk.tgt    = sel_ent[TGT_LSB +: TGT_W];
        lk.frame  = sel_ent[FRAME_LSB +: FRAME_W];
    end

    assign rd_data = rd_q;

    AST_TBL_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ent_q[$past(host_idx)] == $past(wr_data)); // R6

    AST_TBL_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ent_q[$past(host_idx)] == $past(ent_q[host_idx])); // R7

    logic [IDX_W-1:0] unused_w;
    assign unused_w = '0;

endmodule

// File: rtl/dxl_dirmap.sv
module dxl_dirmap #(
    parameter int OFF_W   = 17,
    parameter int WID_W   = 4,
    parameter int WID_LSB = 20,
    parameter int RD_W    = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [OFF_W-1:0] off_in,
    input  logic [WID_W-1:0] wid_in,
    output logic [OFF_W-1:0] off,
    output logic [WID_W-1:0] wid,
    output logic [RD_W-1:0]  rdata
);
    typedef struct packed {
        logic [OFF_W-1:0] off;
        logic [WID_W-1:0] wid;
    } seg_t;

    seg_t seg_d, seg_q;

    always_comb begin
        seg_d = seg_q;
        if (we) begin
            seg_d.off = off_in;
            seg_d.wid = wid_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seg_q <= '0;
        else        seg_q <= seg_d;
    end

    always_comb begin
        rdata = '0;
        rdata[OFF_W-1:0]          = seg_q.off;
        rdata[WID_LSB +: WID_W]   = seg_q.wid;
    end

    assign off = seg_q.off;
    assign wid = seg_q.wid;

    AST_SEG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> off == $past(off_in) && wid == $past(wid_in)); // R8

    AST_SEG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(rdata)); // R8

endmodule

// File: rtl/dma_xlate.sv
module dma_xlate
    import dxl_pkg::*;
#(
    parameter int                  ADDR_W   = 32,
    parameter int                  DEPTH    = 128,
    parameter int                  DM_OFF_W = 17,
    parameter logic [SYS_AW-1:0]   RAM_BASE = 48'h0000_0010_0000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [ADDR_W-1:0]        in_addr,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic [SYS_AW-1:0]        out_addr,
    output logic [TGT_W-1:0]         out_target,
    output logic                     out_barrier,
    output logic                     out_prefetch,
    output logic                     out_precise,
    output logic                     out_coherent,
    output logic                     out_local,
    output logic                     err_invalid,
    input  logic                     tbl_we,
    input  logic [$clog2(DEPTH)-1:0] tbl_idx,
    input  logic [ENT_W-1:0]         tbl_wdata,
    output logic [ENT_W-1:0]         tbl_rdata,
    input  logic                     dm_we,
    input  logic [DM_OFF_W-1:0]      dm_off_in,
    input  logic [TGT_W-1:0]         dm_wid_in,
    output logic [31:0]              dm_rdata
);
    localparam int IDX_W     = $clog2(DEPTH);
    localparam int DIR_SHIFT = ADDR_W - 1;

    typedef struct packed {
        logic              vld;
        logic [SYS_AW-1:0] addr;
        logic [TGT_W-1:0]  tgt;
        attr_t             attr;
        logic              loc;
        logic              err;
    } res_t;

    res_t st_d, st_q;

    win_e                win;
    logic [IDX_W-1:0]    page_idx;
    logic                idx_ok;
    lookup_t             lk;
    logic [DM_OFF_W-1:0] dm_off;
    logic [TGT_W-1:0]    dm_wid;
    logic                accept;
    logic                map_ok;
    logic [SYS_AW-1:0]   dir_addr;

    dxl_window_decode #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_dec (
        .page_bits    (in_addr[ADDR_W-1:PAGE_SHIFT]),
        .win          (win),
        .page_idx     (page_idx),
        .idx_in_range (idx_ok)
    );

    dxl_xlate_table #(.DEPTH(DEPTH)) u_tbl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (tbl_we),
        .host_idx (tbl_idx),
        .wr_data  (tbl_wdata),
        .rd_data  (tbl_rdata),
        .lk_idx   (page_idx),
        .lk       (lk)
    );

    dxl_dirmap #(.OFF_W(DM_OFF_W), .WID_W(TGT_W), .WID_LSB(20), .RD_W(32)) u_dm (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (dm_we),
        .off_in (dm_off_in),
        .wid_in (dm_wid_in),
        .off    (dm_off),
        .wid    (dm_wid),
        .rdata  (dm_rdata)
    );

    assign in_ready = !st_q.vld || out_ready;
    assign accept   = in_valid && in_ready;
    assign map_ok   = idx_ok && lk.valid;
    assign dir_addr = (SYS_AW'(dm_off) << DIR_SHIFT)
                    + SYS_AW'(in_addr[DIR_SHIFT-1:0])
                    + RAM_BASE;

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        if (st_q.vld && out_ready) st_d.vld = 1'b0;
        if (accept) begin
            st_d.vld  = 1'b1;
            st_d.loc  = 1'b0;
            st_d.tgt  = '0;
            st_d.attr = '0;
            unique case (win)
                WIN_LOCAL: begin
                    st_d.addr = SYS_AW'(in_addr);
                    st_d.loc  = 1'b1;
                end
                WIN_MAPPED: begin
                    if (map_ok) begin
                        st_d.addr = {lk.frame, in_addr[PAGE_SHIFT-1:0]};
                        st_d.tgt  = lk.tgt;
                        st_d.attr = lk.attr;
                    end else begin
                        st_d.vld  = 1'b0;
                        st_d.err  = 1'b1;
                    end
                end
                default: begin
                    st_d.addr = dir_addr;
                    st_d.tgt  = dm_wid;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid    = st_q.vld;
    assign out_addr     = st_q.addr;
    assign out_target   = st_q.tgt;
    assign out_barrier  = st_q.attr.barrier;
    assign out_prefetch = st_q.attr.prefetch;
    assign out_precise  = st_q.attr.precise;
    assign out_coherent = st_q.attr.coherent;
    assign out_local    = st_q.loc;
    assign err_invalid  = st_q.err;

    AST_ERR_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        err_invalid |-> !out_valid); // R4

    AST_BAD_MAP_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        accept && win == WIN_MAPPED && !map_ok |=> err_invalid && !out_valid); // R4

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_addr)
                                  && $stable(out_target) && $stable(out_local)); // R9

    AST_LOCAL_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_local |-> out_addr[SYS_AW-1:ADDR_W] == '0
                                && out_target == '0); // R2

    AST_MAP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        accept && win == WIN_MAPPED && map_ok |=> out_valid && !out_local); // R3

    AST_DIRECT_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        accept && win == WIN_DIRECT |=> out_valid && out_target == $past(dm_wid)); // R5

endmodule

// File: tb/dma_xlate_test.sv
module dma_xlate_test;
    localparam logic [47:0] BASE = 48'h0000_0010_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_addr = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [47:0] out_addr;
    logic [3:0]  out_target;
    logic        out_barrier, out_prefetch, out_precise, out_coherent, out_local;
    logic        err_invalid;
    logic        tbl_we = 1'b0;
    logic [6:0]  tbl_idx = '0;
    logic [63:0] tbl_wdata = '0;
    logic [63:0] tbl_rdata;
    logic        dm_we = 1'b0;
    logic [16:0] dm_off_in = '0;
    logic [3:0]  dm_wid_in = '0;
    logic [31:0] dm_rdata;

    always #5 clk = ~clk;

    dma_xlate #(.RAM_BASE(BASE)) uut (.*);

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference model state
    logic [63:0] tbl [128];
    logic [16:0] m_off = '0;
    logic [3:0]  m_wid = '0;
    logic        m_vld = 0, m_err = 0, m_loc = 0;
    logic [47:0] m_addr = '0;
    logic [3:0]  m_tgt = '0;
    logic [3:0]  m_attr = '0;   // barrier, prefetch, precise, coherent
    logic [63:0] m_rd = '0;

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic model_xlate(input logic [31:0] a);
        int unsigned pg;
        longint unsigned sum;
        m_vld = 1; m_loc = 0; m_tgt = 0; m_attr = 0;
        if (a < 32'h4000_0000) begin
            m_addr = {16'h0, a};
            m_loc  = 1;
        end else if (a < 32'h8000_0000) begin
            pg = (a - 32'h4000_0000) / 4096;
            if (pg >= 128 || tbl[pg][0] == 1'b0) begin
                m_vld = 0;
                m_err = 1;
            end else begin
                m_addr = tbl[pg][47:0] & 48'hFFFF_FFFF_F000;
                m_addr = m_addr | 48'(a % 4096);
                m_tgt  = tbl[pg][11:8];
                m_attr = {tbl[pg][4], tbl[pg][3], tbl[pg][2], tbl[pg][1]};
            end
        end else begin
            sum = longint'(m_off) * 64'h8000_0000 + longint'(a - 32'h8000_0000)
                + longint'(BASE);
            m_addr = sum[47:0];
            m_tgt  = m_wid;
        end
    endtask

    task automatic cyc(input string tag);
        logic acc;
        logic [63:0] rd_n;
        #1;
        chk(tag, "in_ready", 64'(in_ready), 64'(!m_vld || out_ready));
        acc = in_valid && (!m_vld || out_ready);
        if (m_vld && out_ready) m_vld = 0;
        m_err = 0;
        if (acc) model_xlate(in_addr);
        rd_n = tbl[tbl_idx];
        if (tbl_we) tbl[tbl_idx] = tbl_wdata;
        if (dm_we) begin m_off = dm_off_in; m_wid = dm_wid_in; end
        m_rd = rd_n;
        @(posedge clk); #1;
        chk(tag, "out_valid", 64'(out_valid), 64'(m_vld));
        chk(tag, "err_invalid", 64'(err_invalid), 64'(m_err));
        if (m_vld) begin
            chk(tag, "out_addr", 64'(out_addr), 64'(m_addr));
            chk(tag, "out_target", 64'(out_target), 64'(m_tgt));
            chk(tag, "attrs", 64'({out_barrier, out_prefetch, out_precise, out_coherent}),
                64'(m_attr));
            chk(tag, "out_local", 64'(out_local), 64'(m_loc));
        end
        chk(tag, "tbl_rdata", tbl_rdata, m_rd);
        chk(tag, "dm_rdata", 64'(dm_rdata), 64'({8'h0, m_wid, 3'b0, m_off}));
    endtask

    task automatic quiet();
        in_valid = 0; tbl_we = 0; dm_we = 0;
    endtask

    task automatic wr_ent(input int i, input logic [63:0] v);
        quiet(); tbl_we = 1; tbl_idx = 7'(i); tbl_wdata = v; cyc("R7");
        tbl_we = 0;
    endtask

    task automatic req(input logic [31:0] a, input string tag);
        quiet(); in_valid = 1; in_addr = a; cyc(tag);
        in_valid = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL R9 watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 128; i++) tbl[i] = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(posedge clk); #1;
        // R1 reset state
        chk("R1", "out_valid", 64'(out_valid), 0);
        chk("R1", "err_invalid", 64'(err_invalid), 0);
        chk("R1", "in_ready", 64'(in_ready), 1);
        chk("R1", "dm_rdata", 64'(dm_rdata), 0);
        tbl_idx = 7'd127; cyc("R1");
        tbl_idx = 7'd0;   cyc("R1");

        // R8 direct-map segment load and read-back
        dm_we = 1; dm_off_in = 17'h1_2345; dm_wid_in = 4'hA; cyc("R8");
        dm_we = 0; cyc("R8");

        // R7 table writes, read-back including remote field
        wr_ent(0,   64'hBEEF_0000_1234_5A1F);
        wr_ent(5,   64'h1234_0000_00AB_C305);
        wr_ent(127, 64'hFFFF_FFFF_FFFF_F71B);
        wr_ent(3,   64'h0000_0000_0777_0E1E);  // valid bit clear
        tbl_idx = 0;   cyc("R7");
        tbl_idx = 127; cyc("R7");
        tbl_idx = 5;   cyc("R7");

        // R2 local window
        req(32'h0000_0000, "R2");
        req(32'h3FFF_FFFF, "R2");
        req(32'h1234_5678, "R2");
        quiet(); cyc("R2");

        // R3 mapped window
        req(32'h4000_0ABC, "R3");
        req(32'h4000_5FFF, "R3");
        req(32'h4007_F001, "R3");
        quiet(); cyc("R3");

        // R4 bad mapped requests
        req(32'h4008_0000, "R4");
        quiet(); cyc("R4");
        req(32'h4000_3123, "R4");
        quiet(); cyc("R4");
        req(32'h7FFF_FFFF, "R4");
        req(32'h4008_0000, "R4");
        quiet(); cyc("R4");

        // R5 direct window with wrap
        req(32'h8000_0000, "R5");
        req(32'hFFFF_FFFF, "R5");
        dm_we = 1; dm_off_in = 17'h1_FFFF; dm_wid_in = 4'h3; cyc("R5");
        req(32'hFFFF_FFFF, "R5");
        req(32'h8765_4321, "R5");
        quiet(); cyc("R5");

        // R6 same-cycle write and translate on entry 5
        quiet(); in_valid = 1; in_addr = 32'h4000_5010;
        tbl_we = 1; tbl_idx = 5; tbl_wdata = 64'h0000_0099_8877_6A13; cyc("R6");
        quiet(); in_valid = 1; in_addr = 32'h4000_5010; cyc("R6");
        quiet(); in_valid = 1; in_addr = 32'h4000_0010;
        tbl_we = 1; tbl_idx = 0; tbl_wdata = 64'h0; cyc("R6");
        quiet(); in_valid = 1; in_addr = 32'h4000_0010; cyc("R6");
        quiet(); cyc("R6");

        // R9 back-pressure and streaming
        out_ready = 0;
        quiet(); in_valid = 1; in_addr = 32'h0000_1111; cyc("R9");
        in_addr = 32'h9000_0000; cyc("R9");
        cyc("R9");
        cyc("R9");
        out_ready = 1; cyc("R9");
        out_ready = 0; in_valid = 0; cyc("R9");
        out_ready = 1; cyc("R9");
        for (int k = 0; k < 8; k++) begin
            in_valid = 1;
            in_addr = (k % 3 == 0) ? 32'h0ABC_0000 + k :
                      (k % 3 == 1) ? 32'h4000_5000 + k : 32'hC000_0000 + k;
            out_ready = (k != 4);
            cyc("R9");
        end
        quiet(); out_ready = 1; cyc("R9"); cyc("R9");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule